// File: doc/BRIEF.md
# PCI Configuration Access Decoder

This block is the host-side front end of the two-port PCI configuration scheme. The host first writes a 32-bit selector into an address port at I/O 0x0CF8. It then reads or writes through a four-byte data window at 0x0CFC to 0x0CFF. The decoder checks the selector's enable bit and bus field. It looks up the device/function in a constant table to pick one of `NUM_TGT` configuration targets, and it forms the byte offset and access length. It then issues a one-cycle request to the chosen target.

The targets sit at consecutive devices, starting at `FIRST_DEV`, on function 0 only. Any other device/function has no target. Reads that reach no target return all ones. Writes aimed at the identity, class and header-type bytes of the header are dropped before they reach the target. Write data is shifted onto the byte lanes that the data port selects, and this lane-aligned value is held for the target.

Top module: `cfg_access_decoder`

## Requirements
- R1: A dword (io_size=2) write to port 0x0CF8 loads the 32-bit selector. A dword read of 0x0CF8 returns that value with io_rvalid.
- R2: A byte or word access (io_size 0 or 1) to port 0x0CF8 is ignored. A write of that size leaves the selector unchanged, and a read of that size produces no io_rvalid.
- R3: After reset the selector and the write-data holding register are both zero, so tgt_wdata is 0 and a selector read returns 0.
- R4: A data-window access reaches a target only when selector bit 31 is 1 and bits 23:16 are 0. Otherwise no tgt_req is raised and a read returns 32'hFFFFFFFF.
- R5: Selector bits 15:8 are the device/function, with device = bits 15:11 and function = bits 10:8. Target i answers device FIRST_DEV+i, function 0. Any other device/function raises no request, and a read of it returns all ones.
- R6: The target offset is {selector[7:2], 2'b00} plus io_port[1:0]. io_size codes 0, 1 and 2 give tgt_len 1, 2 and 4. Code 3 is never forwarded, and a data-window read with code 3 returns all ones.
- R7: A write is forwarded only when its offset is 4 to 7, 12, 13 or 15 and above. Writes to any other offset raise no request and leave tgt_wdata unchanged.
- R8: On a forwarded write, tgt_wdata equals io_wdata shifted left by 8*io_port[1:0]. It holds that value until the next forwarded write.
- R9: tgt_req is one-hot or zero, and it is high for exactly one cycle, the cycle after the edge that samples the host access. A target returns read data in the cycle after its request. io_rvalid and io_rdata appear after the second edge following the host access, and io_rvalid is low after the first.
- R10: Host accesses to ports other than 0x0CF8 and 0x0CFC to 0x0CFF produce no request, no io_rvalid and no change to the selector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_port | input | 16 | Host I/O port address |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 illegal |
| io_wdata | input | 32 | Host write data, right-aligned |
| io_rvalid | output | 1 | Read data valid pulse |
| io_rdata | output | 32 | Read data |
| tgt_req | output | NUM_TGT | One-hot request to a configuration target |
| tgt_wr | output | 1 | Request is a write |
| tgt_offset | output | 8 | Configuration byte offset |
| tgt_len | output | 3 | Access length in bytes (1, 2 or 4) |
| tgt_wdata | output | 32 | Lane-aligned write data |
| tgt_rdata | input | 32*NUM_TGT | Read data from each target, registered by the target |

## Verification
A selector write takes effect at its sampling edge, so the next access already decodes the new value. A target request is visible in the cycle after the host strobe is sampled, and read data with io_rvalid follows one edge later. The bench drives every access on a falling edge and checks io_rvalid low at the first falling edge after sampling. It reads io_rvalid and io_rdata at the second falling edge. A monitor counts request cycles at falling edges, so a pulse longer or shorter than one cycle, or a missing or extra request, shows up as a wrong count.

// File: rtl/cfgd_pkg.sv
// Package: shared encodings and helper functions for the configuration
// access decoder. Assumes 8-bit configuration offsets and 3-bit functions.
package cfgd_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        SRC_ADDR = 2'd0,
        SRC_TGT  = 2'd1,
        SRC_ONES = 2'd2
    } rsrc_e;

    // Offsets the host may write; identity/class/type bytes are protected.
    function automatic logic wr_allowed(input logic [7:0] off);
        return ((off >= 8'd4) && (off <= 8'd7)) || (off == 8'd12) ||
               (off == 8'd13) || (off > 8'd14);
    endfunction

    // Target slot for a device/function; n means "no target present".
    function automatic int devfn_slot(input int devfn, input int first, input int n);
        int dev;
        dev = devfn / 8;
        if ((devfn % 8 == 0) && (dev >= first) && (dev < first + n))
            return dev - first;
        return n;
    endfunction

endpackage

// File: rtl/cfgd_addr_reg.sv
// Selector register behind the address port.
// Assumes the caller has already qualified the write enable (port and size).
module cfgd_addr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Load the selector on a qualified write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/cfgd_route.sv
// Combinational decode of the selector and data-port access into target
// index, offset, length and forward/write-permission flags.
// Assumes targets occupy consecutive devices at function 0.
module cfgd_route
    import cfgd_pkg::*;
#(
    parameter int NUM_TGT   = 4,
    parameter int FIRST_DEV = 0,
    parameter int IDXW      = $clog2(NUM_TGT + 1)
) (
    input  logic            sel_en,
    input  logic [7:0]      sel_bus,
    input  logic [7:0]      sel_devfn,
    input  logic [5:0]      sel_dw,
    input  logic [1:0]      port_lo,
    input  logic [1:0]      size,
    output logic            fwd,
    output logic [IDXW-1:0] tidx,
    output logic [7:0]      offset,
    output logic [2:0]      len,
    output logic            wr_ok
);
    localparam int NFN = 256;

    logic [IDXW-1:0] lut [NFN];

    // Constant device/function to slot table, one entry per code.
    for (genvar g = 0; g < NFN; g++) begin : g_lut
        assign lut[g] = IDXW'(devfn_slot(g, FIRST_DEV, NUM_TGT));
    end

    // Form index, offset and length, and qualify forwarding.
    always_comb begin
        tidx   = lut[sel_devfn];
        offset = {sel_dw, 2'b00} + {6'b0, port_lo};
        unique case (size)
            SZ_BYTE: len = 3'd1;
            SZ_WORD: len = 3'd2;
            default: len = 3'd4;
        endcase
        fwd   = sel_en && (sel_bus == 8'h00) && (tidx != IDXW'(NUM_TGT)) &&
                (size != SZ_BAD);
        wr_ok = wr_allowed(offset);
    end
endmodule

// File: rtl/cfgd_resp.sv
// Read response stage: aligns the response source with the target's
// one-cycle read latency and selects the returned word.
// Assumes the target drives tgt_rdata registered, one cycle after request.
module cfgd_resp
    import cfgd_pkg::*;
#(
    parameter int NUM_TGT = 4,
    parameter int IDXW    = $clog2(NUM_TGT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pend,
    input  logic [1:0]            src,
    input  logic [31:0]           cap,
    input  logic [IDXW-1:0]       tsel,
    input  logic [NUM_TGT*32-1:0] tgt_rdata,
    output logic                  rvalid,
    output logic [31:0]           rdata
);
    logic [1:0]      src_q;
    logic [31:0]     cap_q;
    logic [IDXW-1:0] tsel_q;
    logic [31:0]     tword;

    // Delay the response descriptor by one cycle to meet target data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            src_q  <= SRC_ONES;
            cap_q  <= '0;
            tsel_q <= '0;
        end else begin
            rvalid <= pend;
            src_q  <= src;
            cap_q  <= cap;
            tsel_q <= tsel;
        end
    end

    // Pick the word of the selected target.
    always_comb begin
        tword = '1;
        for (int i = 0; i < NUM_TGT; i++)
            if (tsel_q == IDXW'(i)) tword = tgt_rdata[i*32 +: 32];
    end

    // Choose between selector, target data and all ones.
    always_comb begin
        unique case (src_q)
            SRC_ADDR: rdata = cap_q;
            SRC_TGT:  rdata = tword;
            default:  rdata = '1;
        endcase
    end
endmodule

// File: rtl/cfg_access_decoder.sv
// Top: host-side PCI configuration access decoder with address port and
// four-byte data window. Assumes io_rd and io_wr are single-cycle strobes
// and never asserted together; targets answer reads one cycle after request.
module cfg_access_decoder
    import cfgd_pkg::*;
#(
    parameter int          NUM_TGT   = 4,
    parameter int          FIRST_DEV = 0,
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  io_rd,
    input  logic                  io_wr,
    input  logic [15:0]           io_port,
    input  logic [1:0]            io_size,
    input  logic [31:0]           io_wdata,
    output logic                  io_rvalid,
    output logic [31:0]           io_rdata,
    output logic [NUM_TGT-1:0]    tgt_req,
    output logic                  tgt_wr,
    output logic [7:0]            tgt_offset,
    output logic [2:0]            tgt_len,
    output logic [31:0]           tgt_wdata,
    input  logic [NUM_TGT*32-1:0] tgt_rdata
);
    localparam int IDXW = $clog2(NUM_TGT + 1);

    logic [31:0]     cfg_addr;
    logic            hit_addr, hit_data, is_dword;
    logic            addr_we, fwd, wr_ok, fwd_rd, fwd_wr, rd_claim;
    logic [IDXW-1:0] tidx;
    logic [7:0]      offset;
    logic [2:0]      len;
    logic [1:0]      rd_src;

    logic            pend_q;
    logic [1:0]      src_q;
    logic [31:0]     cap_q;
    logic [IDXW-1:0] tsel_q;

    cfgd_addr_reg #(.W(32)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (addr_we),
        .wdata (io_wdata),
        .q     (cfg_addr)
    );

    cfgd_route #(.NUM_TGT(NUM_TGT), .FIRST_DEV(FIRST_DEV), .IDXW(IDXW)) u_route (
        .sel_en    (cfg_addr[31]),
        .sel_bus   (cfg_addr[23:16]),
        .sel_devfn (cfg_addr[15:8]),
        .sel_dw    (cfg_addr[7:2]),
        .port_lo   (io_port[1:0]),
        .size      (io_size),
        .fwd       (fwd),
        .tidx      (tidx),
        .offset    (offset),
        .len       (len),
        .wr_ok     (wr_ok)
    );

    // Port hit detection and access qualification.
    always_comb begin
        hit_addr = (io_port == ADDR_PORT);
        hit_data = (io_port[15:2] == DATA_PORT[15:2]);
        is_dword = (io_size == SZ_DWORD);
        addr_we  = io_wr && hit_addr && is_dword;
        fwd_rd   = io_rd && hit_data && fwd;
        fwd_wr   = io_wr && hit_data && fwd && wr_ok;
        rd_claim = io_rd && (hit_data || (hit_addr && is_dword));
        if (hit_addr)  rd_src = SRC_ADDR;
        else if (fwd)  rd_src = SRC_TGT;
        else           rd_src = SRC_ONES;
    end

    // Request stage: launch target request, hold lane-shifted write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_req    <= '0;
            tgt_wr     <= 1'b0;
            tgt_offset <= '0;
            tgt_len    <= '0;
            tgt_wdata  <= '0;
            pend_q     <= 1'b0;
            src_q      <= SRC_ONES;
            cap_q      <= '0;
            tsel_q     <= '0;
        end else begin
            tgt_req <= (fwd_rd || fwd_wr) ? (NUM_TGT'(1) << tidx) : '0;
            pend_q  <= rd_claim;
            if (fwd_rd || fwd_wr) begin
                tgt_wr     <= fwd_wr;
                tgt_offset <= offset;
                tgt_len    <= len;
                tsel_q     <= tidx;
            end
            if (fwd_wr)
                tgt_wdata <= io_wdata << {io_port[1:0], 3'b000};
            if (rd_claim) begin
                src_q <= rd_src;
                cap_q <= cfg_addr;
            end
        end
    end

    cfgd_resp #(.NUM_TGT(NUM_TGT), .IDXW(IDXW)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend_q),
        .src       (src_q),
        .cap       (cap_q),
        .tsel      (tsel_q),
        .tgt_rdata (tgt_rdata),
        .rvalid    (io_rvalid),
        .rdata     (io_rdata)
    );
endmodule

// File: rtl/cfgd_chk.sv
// Checker: temporal properties of the decoder's ports, bound to the top.
module cfgd_chk #(
    parameter int NUM_TGT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               io_rd,
    input logic               io_wr,
    input logic               io_rvalid,
    input logic [NUM_TGT-1:0] tgt_req,
    input logic               tgt_wr,
    input logic [7:0]         tgt_offset,
    input logic [2:0]         tgt_len,
    input logic [31:0]        tgt_wdata
);
    // R9
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_req));

    // R9
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tgt_req) |-> $past(io_rd || io_wr));

    // R9
    rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tgt_req) && !tgt_wr) |=> io_rvalid);

    // R9
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |-> $past(io_rd, 2));

    // R7
    wr_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tgt_req) && tgt_wr) |->
        ((tgt_offset inside {[8'd4:8'd7], 8'd12, 8'd13}) || (tgt_offset > 8'd14)));

    // R6
    len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tgt_req) |-> (tgt_len inside {3'd1, 3'd2, 3'd4}));

    // R3
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((tgt_wdata == 32'h0) && !io_rvalid && (tgt_req == '0)));
endmodule

bind cfg_access_decoder cfgd_chk #(.NUM_TGT(NUM_TGT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_rvalid  (io_rvalid),
    .tgt_req    (tgt_req),
    .tgt_wr     (tgt_wr),
    .tgt_offset (tgt_offset),
    .tgt_len    (tgt_len),
    .tgt_wdata  (tgt_wdata)
);

// File: tb/cfg_access_decoder_tb_top.sv
module cfg_access_decoder_tb_top;
    localparam int NT = 4;
    localparam logic [15:0] PA = 16'h0CF8;
    localparam logic [15:0] PD = 16'h0CFC;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              io_rd, io_wr;
    logic [15:0]       io_port;
    logic [1:0]        io_size;
    logic [31:0]       io_wdata;
    logic              io_rvalid;
    logic [31:0]       io_rdata;
    logic [NT-1:0]     tgt_req;
    logic              tgt_wr;
    logic [7:0]        tgt_offset;
    logic [2:0]        tgt_len;
    logic [31:0]       tgt_wdata;
    logic [NT*32-1:0]  tgt_rdata;
    logic [31:0]       trd [NT];

    int n_chk = 0, n_fail = 0, req_cnt = 0;
    logic [7:0]  last_off;
    logic [2:0]  last_len;
    logic        last_wr;
    logic [31:0] last_tgt;
    bit          done = 0;

    always #10 clk = ~clk;

    cfg_access_decoder #(.NUM_TGT(NT)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr), .io_port(io_port),
        .io_size(io_size), .io_wdata(io_wdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .tgt_req(tgt_req), .tgt_wr(tgt_wr), .tgt_offset(tgt_offset), .tgt_len(tgt_len),
        .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
    );

    // Target models: registered read data encodes identity, offset and length.
    always @(posedge clk) begin
        for (int i = 0; i < NT; i++) begin
            if (!rst_n) trd[i] <= 32'h0;
            else if (tgt_req[i] && !tgt_wr)
                trd[i] <= {8'hC0 + 8'(i), 8'h00, tgt_offset, 5'd0, tgt_len};
        end
    end
    for (genvar g = 0; g < NT; g++) begin : g_pack
        assign tgt_rdata[g*32 +: 32] = trd[g];
    end

    // Request monitor, sampled at falling edges.
    always @(negedge clk) begin
        if (|tgt_req) begin
            req_cnt  = req_cnt + 1;
            last_off = tgt_offset;
            last_len = tgt_len;
            last_wr  = tgt_wr;
            for (int i = 0; i < NT; i++) if (tgt_req[i]) last_tgt = 32'(i);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [15:0] port, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk); io_wr = 1'b1; io_port = port; io_size = sz; io_wdata = d;
        @(negedge clk); io_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_read(input logic [15:0] port, input logic [1:0] sz,
                             output logic early, output logic valid, output logic [31:0] d);
        @(negedge clk); io_rd = 1'b1; io_port = port; io_size = sz;
        @(negedge clk); io_rd = 1'b0; early = io_rvalid;
        @(negedge clk); valid = io_rvalid; d = io_rdata;
    endtask

    task automatic wr_case(input string tag, input logic [31:0] cfg, input logic [1:0] plo,
                           input logic [1:0] sz, input logic [31:0] d, input int pass,
                           input logic [7:0] exp_off, input logic [2:0] exp_len,
                           input logic [31:0] exp_wd);
        int c0;
        logic [31:0] wd0;
        host_write(PA, 2'd2, cfg);
        c0  = req_cnt;
        wd0 = tgt_wdata;
        host_write(PD | {14'd0, plo}, sz, d);
        check({tag, " request count"}, 32'(req_cnt - c0), 32'(pass));
        if (pass != 0) begin
            check({tag, " offset"}, {24'd0, last_off}, {24'd0, exp_off});
            check({tag, " length"}, {29'd0, last_len}, {29'd0, exp_len});
            check({tag, " write flag"}, {31'd0, last_wr}, 32'd1);
            check("R8 lane-shifted data", tgt_wdata, exp_wd);
        end else begin
            check({tag, " dropped write keeps tgt_wdata"}, tgt_wdata, wd0);
        end
    endtask

    typedef struct packed {
        logic [31:0] cfg;
        logic [1:0]  plo;
        logic [1:0]  sz;
        logic [31:0] exp;
    } vec_t;

    // Read vectors: selector, port low bits, size code, expected data.
    localparam vec_t VEC [10] = '{
        '{32'h8000_0000, 2'd0, 2'd2, 32'hC000_0004},   // R5 device 0
        '{32'h8000_0810, 2'd2, 2'd1, 32'hC100_1202},   // R6 word at 0x12
        '{32'h8000_1804, 2'd3, 2'd0, 32'hC300_0701},   // R6 byte at 0x07
        '{32'h0000_0800, 2'd0, 2'd2, 32'hFFFF_FFFF},   // R4 disabled
        '{32'h8001_0800, 2'd0, 2'd2, 32'hFFFF_FFFF},   // R4 bus 1
        '{32'h8000_2000, 2'd0, 2'd2, 32'hFFFF_FFFF},   // R5 device 4 absent
        '{32'h8000_0900, 2'd0, 2'd2, 32'hFFFF_FFFF},   // R5 function 1 absent
        '{32'h8000_10FC, 2'd1, 2'd0, 32'hC200_FD01},   // R6 top offset
        '{32'h8000_0000, 2'd0, 2'd3, 32'hFFFF_FFFF},   // R6 illegal size
        '{32'h8000_0803, 2'd0, 2'd2, 32'hC100_0004}    // R6 selector bits 1:0 ignored
    };

    initial begin
        logic e, v;
        logic [31:0] d;
        int c0;
        rst_n = 1'b0; io_rd = 1'b0; io_wr = 1'b0; io_port = '0; io_size = '0; io_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        check("R3 tgt_wdata after reset", tgt_wdata, 32'h0);
        host_read(PA, 2'd2, e, v, d);
        check("R3 selector after reset", d, 32'h0);

        // R1 selector write and read back, R9 response timing
        host_write(PA, 2'd2, 32'h1357_9BDF);
        host_read(PA, 2'd2, e, v, d);
        check("R1 selector read back", d, 32'h1357_9BDF);
        check("R9 rvalid on second edge", {31'd0, v}, 32'd1);
        check("R9 rvalid low on first edge", {31'd0, e}, 32'd0);

        // R2 narrow selector accesses ignored
        host_write(PA, 2'd1, 32'hFFFF_0000);
        host_read(PA, 2'd2, e, v, d);
        check("R2 word write ignored", d, 32'h1357_9BDF);
        host_read(PA, 2'd0, e, v, d);
        check("R2 byte read no rvalid", {31'd0, e | v}, 32'd0);

        // R10 foreign ports
        c0 = req_cnt;
        host_write(16'h0CF9, 2'd2, 32'h0);
        host_read(16'h0CF0, 2'd2, e, v, d);
        check("R10 foreign read no rvalid", {31'd0, e | v}, 32'd0);
        host_read(PA, 2'd2, e, v, d);
        check("R10 selector unchanged", d, 32'h1357_9BDF);
        check("R10 no target request", 32'(req_cnt - c0), 32'd0);

        // R4 R5 R6 read vector table
        for (int i = 0; i < 10; i++) begin
            host_write(PA, 2'd2, VEC[i].cfg);
            c0 = req_cnt;
            host_read(PD | {14'd0, VEC[i].plo}, VEC[i].sz, e, v, d);
            check($sformatf("R4/R5/R6 vector %0d data", i), d, VEC[i].exp);
            check($sformatf("R9 vector %0d rvalid", i), {31'd0, v}, 32'd1);
            check($sformatf("R4/R5 vector %0d request count", i), 32'(req_cnt - c0),
                  (VEC[i].exp == 32'hFFFF_FFFF) ? 32'd0 : 32'd1);
        end

        // R7 R8 write filter and lane shift on device 1
        wr_case("R7 offset 0x00", 32'h8000_0800, 2'd0, 2'd2, 32'h1111_1111, 0, 8'h00, 3'd4, 32'h0);
        wr_case("R7 offset 0x04", 32'h8000_0804, 2'd0, 2'd2, 32'hCAFE_0007, 1, 8'h04, 3'd4, 32'hCAFE_0007);
        wr_case("R7 offset 0x08", 32'h8000_0808, 2'd0, 2'd2, 32'h2222_2222, 0, 8'h00, 3'd4, 32'h0);
        wr_case("R7 offset 0x0D", 32'h8000_080C, 2'd1, 2'd0, 32'h0000_005A, 1, 8'h0D, 3'd1, 32'h0000_5A00);
        wr_case("R7 offset 0x0E", 32'h8000_080C, 2'd2, 2'd0, 32'h0000_0033, 0, 8'h00, 3'd1, 32'h0);
        wr_case("R7 offset 0x0F", 32'h8000_080C, 2'd3, 2'd0, 32'h0000_0077, 1, 8'h0F, 3'd1, 32'h7700_0000);
        wr_case("R8 word at 0x06", 32'h8000_0804, 2'd2, 2'd1, 32'h0000_ABCD, 1, 8'h06, 3'd2, 32'hABCD_0000);
        check("R5 write routed to target 1", last_tgt, 32'd1);
        wr_case("R4 disabled write", 32'h0000_0804, 2'd0, 2'd2, 32'h4444_4444, 0, 8'h00, 3'd4, 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule